// File: doc/BRIEF.md
# Graceful Stop and Poll Controller

This block sits beside the DMA engines of an Ethernet controller. It watches writes to the DMA control register and the frame-in-progress indications from the receive and transmit frame engines. From these it produces the graceful-stop-complete events for each direction, and it runs the periodic timer that asks the transmit side to scan descriptor ring 0 while polling is enabled.

A stop request for a direction is made by writing the control register with that direction's stop bit set. If that engine is idle, the completion event fires straight away. If a frame is in flight, the block records the request and fires the event once, when that frame ends. Writing the control register with the poll-hold bit clear restarts the poll timer from one full period. At each expiry, the timer re-arms only if the poll-hold bit is still clear. Each expiry also requests a ring-0 scan, but only while both the poll-hold bit and the stored transmit-stop bit are clear.

Each stop direction uses one `gs_stop_tracker` state machine. Its states are `ST_IDLE` and `ST_WAIT`. An `ST_IDLE` request with the engine idle completes at once and stays in `ST_IDLE`. An `ST_IDLE` request with the engine busy moves to `ST_WAIT`. In `ST_WAIT`, the engine going idle completes the request and returns to `ST_IDLE`. The poll timer is the `gs_poll_timer` state machine, with states `PL_OFF` and `PL_RUN`. A restart write moves to `PL_RUN` from either state. At expiry, `PL_RUN` stays in `PL_RUN` if the poll-hold bit is clear and moves to `PL_OFF` if it is set. Nothing else changes state.

Top module: `gs_poll_ctrl`

## Requirements
- R1: After reset all three outputs are low, no stop is pending and the poll timer is off, so no scan request appears until the control register is written with the poll-hold bit (`ctrl_hold`) at 0.
- R2: A control write with `ctrl_rx_stop`=1, sampled at a clock edge where `rx_busy` is 0, makes `rx_stop_done` high for exactly the one cycle that follows that edge.
- R3: If `rx_busy` is 1 at that write edge, `rx_stop_done` stays low while `rx_busy` stays 1. It goes high for one cycle following the first edge at which `rx_busy` is sampled 0.
- R4: Transmit stop behaves as in R2 and R3, using `ctrl_tx_stop`, `tx_busy` and `tx_stop_done`.
- R5: A control write with `ctrl_hold`=0 restarts the timer. The next `ring0_scan` pulse comes in the cycle following the edge POLL_CYCLES clocks after the write edge. A restart in mid-period discards the old schedule.
- R6: While `ctrl_hold` stays 0 and `ctrl_tx_stop` was last written 0, `ring0_scan` pulses for one cycle every POLL_CYCLES cycles.
- R7: While the stored transmit-stop bit is 1, expiries produce no `ring0_scan` pulse.
- R8: After a write with `ctrl_hold`=1, the running timer stops at its next expiry. That expiry and all later cycles give no scan until a restart.
- R9: Extra stop requests made while a stop is already pending do not add completions: exactly one pulse follows the frame end.
- R10: A control write with a stop bit at 0 produces no completion pulse for that direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe, one cycle per write |
| ctrl_rx_stop | input | 1 | Write data: graceful receive stop request |
| ctrl_tx_stop | input | 1 | Write data: graceful transmit stop request; stored, masks scans |
| ctrl_hold | input | 1 | Write data: poll-hold bit; 0 restarts and keeps the poll timer running |
| rx_busy | input | 1 | Receive frame in progress |
| tx_busy | input | 1 | Transmit frame in progress |
| rx_stop_done | output | 1 | One-cycle receive-stop-complete event |
| tx_stop_done | output | 1 | One-cycle transmit-stop-complete event |
| ring0_scan | output | 1 | One-cycle request to scan transmit ring 0 |

## Verification
The assertions assume that a busy line does not fall and rise again within the same clock period. They also assume that POLL_CYCLES is at least 2, so a one-cycle scan pulse can never repeat back to back. The stimulus drives every input on the falling edge and holds it for a whole cycle. It raises or drops a busy line only between writes, and runs the timer with a period of 8. It never places a write with the poll-hold bit set on the exact edge of an expiry, so the stored bit at each expiry is unambiguous.

// File: rtl/gs_pkg.sv
package gs_pkg;

    // Per-direction stop tracking
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } stop_state_e;

    // Poll timer
    typedef enum logic {
        PL_OFF = 1'b0,
        PL_RUN = 1'b1
    } poll_state_e;

    // Stored control bits that later logic consults
    typedef struct packed {
        logic tx_stop;
        logic hold;
    } ctrl_bits_t;

    localparam int NUM_DIRS = 2;
    localparam int DIR_RX   = 0;
    localparam int DIR_TX   = 1;

endpackage

// File: rtl/gs_stop_tracker.sv
module gs_stop_tracker
    import gs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic busy_i,
    output logic done_o
);

    stop_state_e state_q;
    stop_state_e state_d;
    logic        done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i && busy_i) state_d = ST_WAIT;
            ST_WAIT: if (!busy_i)         state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: done_q <= req_i && !busy_i;
                ST_WAIT: done_q <= !busy_i;
                default: done_q <= 1'b0;
            endcase
        end
    end

    assign done_o = done_q;

    // R2
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !$past(busy_i));

    // R3
    release_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !busy_i) |=> done_o);

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && busy_i) |=> !done_o);

endmodule

// File: rtl/gs_poll_timer.sv
module gs_poll_timer
    import gs_pkg::*;
#(
    parameter int PERIOD = 2_000_000  // must be at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic hold_i,
    input  logic tx_stop_i,
    output logic scan_o
);

    localparam int          CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    poll_state_e   state_q;
    poll_state_e   state_d;
    logic [CW-1:0] cnt_q;
    logic          expire;
    logic          scan_q;

    assign expire = (state_q == PL_RUN) && (cnt_q == '0) && !restart_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PL_OFF: if (restart_i) state_d = PL_RUN;
            PL_RUN: begin
                if (restart_i)   state_d = PL_RUN;
                else if (expire) state_d = hold_i ? PL_OFF : PL_RUN;
            end
            default: state_d = PL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PL_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            scan_q <= 1'b0;
        end else begin
            scan_q <= expire && !hold_i && !tx_stop_i;
            if (restart_i)
                cnt_q <= LAST;
            else if (expire)
                cnt_q <= LAST;
            else if (state_q == PL_RUN)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    assign scan_o = scan_q;

    // R5
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (state_q == PL_RUN && cnt_q == LAST));

    // R6
    scan_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_o |=> !scan_o);

    // R7
    stop_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_o |-> !$past(tx_stop_i));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PL_OFF) |=> !scan_o);

endmodule

// File: rtl/gs_poll_ctrl.sv
module gs_poll_ctrl
    import gs_pkg::*;
#(
    parameter int POLL_CYCLES = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic ctrl_rx_stop,
    input  logic ctrl_tx_stop,
    input  logic ctrl_hold,
    input  logic rx_busy,
    input  logic tx_busy,
    output logic rx_stop_done,
    output logic tx_stop_done,
    output logic ring0_scan
);

    ctrl_bits_t          ctrl_q;
    logic [NUM_DIRS-1:0] stop_req;
    logic [NUM_DIRS-1:0] eng_busy;
    logic [NUM_DIRS-1:0] stop_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q.tx_stop <= ctrl_tx_stop;
            ctrl_q.hold    <= ctrl_hold;
        end
    end

    assign stop_req[DIR_RX] = ctrl_we && ctrl_rx_stop;
    assign stop_req[DIR_TX] = ctrl_we && ctrl_tx_stop;
    assign eng_busy[DIR_RX] = rx_busy;
    assign eng_busy[DIR_TX] = tx_busy;

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
        gs_stop_tracker u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (stop_req[d]),
            .busy_i (eng_busy[d]),
            .done_o (stop_done[d])
        );
    end

    gs_poll_timer #(.PERIOD(POLL_CYCLES)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctrl_we && !ctrl_hold),
        .hold_i    (ctrl_q.hold),
        .tx_stop_i (ctrl_q.tx_stop),
        .scan_o    (ring0_scan)
    );

    assign rx_stop_done = stop_done[DIR_RX];
    assign tx_stop_done = stop_done[DIR_TX];

    // R10
    no_req_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !ctrl_rx_stop && !rx_busy && $past(!rx_busy)) |=> !rx_stop_done);

endmodule

// File: tb/gs_poll_ctrl_tb.sv
module gs_poll_ctrl_tb;

    localparam int P = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 1'b0, ctrl_rx_stop = 1'b0, ctrl_tx_stop = 1'b0, ctrl_hold = 1'b1;
    logic rx_busy = 1'b0, tx_busy = 1'b0;
    logic rx_stop_done, tx_stop_done, ring0_scan;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gs_poll_ctrl #(.POLL_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .ctrl_rx_stop(ctrl_rx_stop), .ctrl_tx_stop(ctrl_tx_stop), .ctrl_hold(ctrl_hold),
        .rx_busy(rx_busy), .tx_busy(tx_busy),
        .rx_stop_done(rx_stop_done), .tx_stop_done(tx_stop_done), .ring0_scan(ring0_scan)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, got, exp, $time);
        end
    endtask

    // One write; returns just after the write edge.
    task automatic wr(input logic rs, input logic ts, input logic hd);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_rx_stop = rs; ctrl_tx_stop = ts; ctrl_hold = hd;
        @(posedge clk);
        #1 ctrl_we = 1'b0;
    endtask

    task automatic t_reset();
        chk(rx_stop_done, 1'b0, "R1 rx_done");
        chk(tx_stop_done, 1'b0, "R1 tx_done");
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            chk(ring0_scan, 1'b0, "R1 scan off");
        end
    endtask

    task automatic t_rx_idle();
        wr(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(rx_stop_done, 1'b1, "R2 rx immediate");
        chk(tx_stop_done, 1'b0, "R10 tx not requested");
        @(negedge clk);
        chk(rx_stop_done, 1'b0, "R2 one cycle");
        wr(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk(rx_stop_done, 1'b0, "R10 bit clear");
    endtask

    task automatic t_rx_defer();
        @(negedge clk) rx_busy = 1'b1;
        wr(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rx_stop_done, 1'b0, "R3 wait while busy");
        end
        wr(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(rx_stop_done, 1'b0, "R9 repeat while pending");
        rx_busy = 1'b0;
        @(negedge clk);
        chk(rx_stop_done, 1'b1, "R3 fires at frame end");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(rx_stop_done, 1'b0, "R9 single completion");
        end
    endtask

    task automatic t_tx();
        wr(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk(tx_stop_done, 1'b1, "R4 tx immediate");
        chk(rx_stop_done, 1'b0, "R10 rx not requested");
        @(negedge clk);
        chk(tx_stop_done, 1'b0, "R4 one cycle");
        tx_busy = 1'b1;
        wr(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tx_stop_done, 1'b0, "R4 tx wait");
        end
        tx_busy = 1'b0;
        @(negedge clk);
        chk(tx_stop_done, 1'b1, "R4 tx deferred");
        @(negedge clk);
        chk(tx_stop_done, 1'b0, "R4 tx once");
    endtask

    // Scan expected on negedge n where (n-1)%P==0, n>1, counting from the write edge.
    task automatic expect_scans(input int upto, input string tag);
        for (int n = 1; n <= upto; n++) begin
            @(negedge clk);
            chk(ring0_scan, (n > 1 && (n - 1) % P == 0), tag);
        end
    endtask

    task automatic t_poll();
        wr(1'b0, 1'b0, 1'b0);
        expect_scans(3 * P + 1, "R6 periodic scan");
        wr(1'b0, 1'b0, 1'b0);
        expect_scans(4, "R5 restart");
        wr(1'b0, 1'b0, 1'b0);
        expect_scans(P + 1, "R5 mid-period restart");
    endtask

    task automatic t_gts();
        wr(1'b0, 1'b1, 1'b0);
        expect_scans(0, "R7");
        for (int n = 1; n <= 2 * P + 2; n++) begin
            @(negedge clk);
            chk(ring0_scan, 1'b0, "R7 scan masked");
        end
        wr(1'b0, 1'b0, 1'b0);
        expect_scans(P + 1, "R7 unmasked again");
    endtask

    task automatic t_hold();
        wr(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        wr(1'b0, 1'b0, 1'b1);
        for (int n = 1; n <= 3 * P; n++) begin
            @(negedge clk);
            chk(ring0_scan, 1'b0, "R8 stopped");
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rx_idle();
        t_rx_defer();
        t_tx();
        t_poll();
        t_gts();
        t_hold();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule